// File: doc/BRIEF.md
# SPI Master with Hardware CRC

This block is a serial peripheral master for one slave. A single accept handshake starts a transfer. The block then lowers chip select and shifts one data frame out on MOSI, most significant bit first. In full-duplex mode it collects the MISO bits at the same time. A 3-bit prescaler sets the serial clock rate from the system clock. Two further configuration bits set the idle clock level and which clock edge samples the data.

Two bit-serial CRC registers run next to the shifter. One of them follows the bits sent on MOSI and the other follows the bits sampled on MISO. Both use the same programmable polynomial. When a transfer asks for it, the transmit CRC goes out as a second frame of the same length inside the same chip-select window. The frame that arrives in that slot is then compared with the receive CRC, and a sticky error flag reports a mismatch. This is the framing used by card-style command/data links.

All configuration is sampled at the accept cycle and held for the whole transfer.

Top module: `spim_crc_master`

## Requirements
- R1: A transfer is accepted in a cycle with `tx_valid` high while `tx_ready` is high. One clock later `cs_n` is low and `busy` is high. `tx_ready` is high only while no transfer runs, and a `tx_valid` raised during a transfer is ignored.
- R2: The SCK period is 2^(`cfg_presc`+1) system clocks, so settings 0..7 give divide ratios 2..256. Between transfers SCK rests at the `cfg_cpol` level.
- R3: `cs_n` falls two SCK half-periods before the first SCK edge. It rises one full SCK period after the last SCK edge. `busy` stays high for the whole time `cs_n` is low.
- R4: With `cfg_cpha`=0, each MOSI bit is stable before the leading edge (the edge away from the idle level) and is sampled there. With `cfg_cpha`=1, the bit is sampled on the trailing edge. Bits go out most significant first.
- R5: `cfg_wide`=1 gives 16-bit frames. `cfg_wide`=0 gives 8-bit frames that send `tx_data[7:0]` and return zeros in `rx_data[15:8]`.
- R6: In full-duplex mode, `rx_data` holds the bits sampled on MISO. `rx_valid` pulses for exactly one clock, one clock after the last data-frame edge, while `cs_n` is still low. No pulse follows a CRC frame.
- R7: In transmit-only mode (`cfg_txonly`=1), `rx_valid` never pulses and `crc_err` stays 0.
- R8: For each data bit b, each CRC register computes f = c[top] ^ b and then c = ((c << 1) ^ (f ? poly : 0)), cut to the frame width. Here top is bit 15 for wide frames and bit 7 for narrow ones. Both registers start at zero when `tx_crc_init` is 1 at accept; otherwise they continue from their previous value.
- R9: With `tx_crc_after`=1, a second frame of the same length carrying the transmit CRC follows the data frame under the same chip select. The bits of this frame do not update either CRC register.
- R10: At the end of the CRC frame in full-duplex mode, `crc_err` is set if the received frame differs from the receive CRC. It then holds until the next accept clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_presc | input | 3 | Rate select, SCK = clk / 2^(value+1) |
| cfg_cpol | input | 1 | Idle SCK level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_wide | input | 1 | 1: 16-bit frames, 0: 8-bit frames |
| cfg_txonly | input | 1 | 1: transmit-only, receive path ignored |
| crc_poly | input | 16 | CRC polynomial (low 8 bits used for narrow frames) |
| tx_crc_after | input | 1 | Append the transmit CRC frame after the data frame |
| tx_crc_init | input | 1 | Clear both CRC registers at accept |
| tx_data | input | 16 | Data frame to send |
| tx_valid | input | 1 | Request to start a transfer |
| tx_ready | output | 1 | High while idle, a request is taken |
| rx_data | output | 16 | Last received data frame |
| rx_valid | output | 1 | One-clock pulse when `rx_data` is updated |
| busy | output | 1 | Transfer in progress |
| crc_err | output | 1 | Received CRC frame did not match |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its default parameters: a 16-bit maximum frame, an 8-bit short frame and a 3-bit prescaler. With these values it can step through all eight divide ratios, up to the slowest of 256, and use both frame widths. MISO is looped back from MOSI, and can be inverted, so the received data and the received CRC frame can be predicted. The inverted case makes the receive CRC differ from the transmit CRC and so exercises the mismatch flag. One vector skips the CRC clear, which shows that CRC state carries over from one transfer to the next.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_GAP,
      ST_TAIL
   } spim_state_e;
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
   parameter int PRESC_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   output logic               tick
);
   localparam int CNT_W = (1 << PRESC_W) - 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   // half SCK period is 2^presc system clocks
   assign lim  = (CNT_W'(1) << presc) - CNT_W'(1);
   assign tick = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr || tick)  cnt <= '0;
      else if (run)          cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/spim_edge_dec.sv
module spim_edge_dec #(
   parameter int EDGE_W = 5
) (
   input  logic [EDGE_W-1:0] edge_idx,
   input  logic [EDGE_W-1:0] last_idx,
   input  logic              cpha,
   output logic              do_sample,
   output logic              do_shift,
   output logic              is_last
);
   logic odd;
   logic first;

   assign odd     = edge_idx[0];
   assign first   = (edge_idx == '0);
   assign is_last = (edge_idx == last_idx);

   // even edges lead; phase picks which class samples, the other shifts
   assign do_sample = cpha ? odd : !odd;
   assign do_shift  = cpha ? (!odd && !first) : (odd && !is_last);
endmodule

// File: rtl/spim_crc_reg.sv
module spim_crc_reg #(
   parameter int W       = 16,
   parameter int SHORT_W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic         bit_in,
   input  logic         wide,
   input  logic [W-1:0] poly,
   output logic [W-1:0] crc
);
   logic         top;
   logic         fb;
   logic [W-1:0] mask;
   logic [W-1:0] nxt;

   assign mask = {{(W-SHORT_W){wide}}, {SHORT_W{1'b1}}};
   assign top  = wide ? crc[W-1] : crc[SHORT_W-1];
   assign fb   = top ^ bit_in;
   assign nxt  = ((crc << 1) ^ (fb ? poly : '0)) & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= '0;
      else if (clr)   crc <= '0;
      else if (step)  crc <= nxt;
   end
endmodule

// File: rtl/spim_crc_master.sv
module spim_crc_master
   import spim_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int SHORT_W = 8,
   parameter int PRESC_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRESC_W-1:0] cfg_presc,
   input  logic               cfg_cpol,
   input  logic               cfg_cpha,
   input  logic               cfg_wide,
   input  logic               cfg_txonly,
   input  logic [DATA_W-1:0]  crc_poly,
   input  logic               tx_crc_after,
   input  logic               tx_crc_init,
   input  logic [DATA_W-1:0]  tx_data,
   input  logic               tx_valid,
   output logic               tx_ready,
   output logic [DATA_W-1:0]  rx_data,
   output logic               rx_valid,
   output logic               busy,
   output logic               crc_err,
   output logic               sck,
   output logic               mosi,
   input  logic               miso,
   output logic               cs_n
);
   localparam int EDGE_W = $clog2(2 * DATA_W);
   localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * DATA_W - 1);
   localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(2 * SHORT_W - 1);

   initial begin
      assert (DATA_W > SHORT_W && SHORT_W >= 2)
         else $error("frame widths: DATA_W must exceed SHORT_W >= 2");
      assert (PRESC_W >= 1 && PRESC_W <= 4)
         else $error("PRESC_W out of range 1..4");
   end

   spim_state_e         state;
   logic [PRESC_W-1:0]  r_presc;
   logic                r_cpha, r_wide, r_txonly, r_crc_after, crc_phase;
   logic [DATA_W-1:0]   r_poly, tx_sh, rx_sh, frame_mask;
   logic [EDGE_W-1:0]   edge_cnt, last_idx;
   logic                tail_cnt, fin;
   logic                tick, edge_go, do_sample, do_shift, is_last;
   logic                accept, crc_clr, crc_step;
   logic [1:0]          crc_bit;
   logic [DATA_W-1:0]   crc_val [2];

   assign tx_ready   = (state == ST_IDLE);
   assign busy       = (state != ST_IDLE);
   assign accept     = tx_valid && tx_ready;
   assign frame_mask = {{(DATA_W-SHORT_W){r_wide}}, {SHORT_W{1'b1}}};
   assign last_idx   = r_wide ? LAST_WIDE : LAST_NARROW;
   assign mosi       = r_wide ? tx_sh[DATA_W-1] : tx_sh[SHORT_W-1];
   assign edge_go    = (state == ST_SHIFT) && tick;

   spim_clkgen #(.PRESC_W(PRESC_W)) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .run   (busy),
      .presc (r_presc),
      .tick  (tick)
   );

   spim_edge_dec #(.EDGE_W(EDGE_W)) u_edge (
      .edge_idx  (edge_cnt),
      .last_idx  (last_idx),
      .cpha      (r_cpha),
      .do_sample (do_sample),
      .do_shift  (do_shift),
      .is_last   (is_last)
   );

   // index 0 follows MOSI, index 1 follows MISO
   assign crc_bit  = {miso, mosi};
   assign crc_clr  = accept && tx_crc_init;
   assign crc_step = edge_go && do_sample && !crc_phase;

   for (genvar g = 0; g < 2; g++) begin : g_crc
      spim_crc_reg #(.W(DATA_W), .SHORT_W(SHORT_W)) u_crc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (crc_clr),
         .step   (crc_step),
         .bit_in (crc_bit[g]),
         .wide   (r_wide),
         .poly   (r_poly),
         .crc    (crc_val[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cs_n        <= 1'b1;
         sck         <= 1'b0;
         r_presc     <= '0;
         r_cpha      <= 1'b0;
         r_wide      <= 1'b0;
         r_txonly    <= 1'b0;
         r_crc_after <= 1'b0;
         r_poly      <= '0;
         crc_phase   <= 1'b0;
         tx_sh       <= '0;
         rx_sh       <= '0;
         edge_cnt    <= '0;
         tail_cnt    <= 1'b0;
         fin         <= 1'b0;
         rx_data     <= '0;
         rx_valid    <= 1'b0;
         crc_err     <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         fin      <= 1'b0;
         case (state)
            ST_IDLE: begin
               sck <= cfg_cpol;
               if (tx_valid) begin
                  r_presc     <= cfg_presc;
                  r_cpha      <= cfg_cpha;
                  r_wide      <= cfg_wide;
                  r_txonly    <= cfg_txonly;
                  r_crc_after <= tx_crc_after;
                  r_poly      <= crc_poly;
                  tx_sh       <= tx_data & {{(DATA_W-SHORT_W){cfg_wide}}, {SHORT_W{1'b1}}};
                  crc_phase   <= 1'b0;
                  crc_err     <= 1'b0;
                  cs_n        <= 1'b0;
                  state       <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  edge_cnt <= '0;
                  state    <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  sck <= !sck;
                  if (do_sample) rx_sh <= {rx_sh[DATA_W-2:0], miso};
                  if (do_shift)  tx_sh <= tx_sh << 1;
                  if (is_last) begin
                     fin      <= 1'b1;
                     tail_cnt <= 1'b0;
                     state    <= (r_crc_after && !crc_phase) ? ST_GAP : ST_TAIL;
                  end else begin
                     edge_cnt <= edge_cnt + EDGE_W'(1);
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  tx_sh     <= crc_val[0];
                  crc_phase <= 1'b1;
                  edge_cnt  <= '0;
                  state     <= ST_SHIFT;
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  if (tail_cnt) begin
                     cs_n  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     tail_cnt <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase

         // frame completion, one clock after its last edge
         if (fin && !r_txonly) begin
            if (!crc_phase) begin
               rx_valid <= 1'b1;
               rx_data  <= rx_sh & frame_mask;
            end else if ((rx_sh & frame_mask) != crc_val[1]) begin
               crc_err <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spim_crc_master_chk.sv
module spim_crc_master_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_valid,
   input logic tx_ready,
   input logic busy,
   input logic cs_n,
   input logic rx_valid,
   input logic crc_err
);
   assert_accept_selects_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !cs_n && busy);

   assert_select_under_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   assert_release_with_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $rose(cs_n));

   assert_rx_inside_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !cs_n);

   assert_rx_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_err_set_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_err) |-> !cs_n);
endmodule

bind spim_crc_master spim_crc_master_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .busy     (busy),
   .cs_n     (cs_n),
   .rx_valid (rx_valid),
   .crc_err  (crc_err)
);

// File: tb/spim_crc_master_bench.sv
module spim_crc_master_bench;
   typedef struct packed {
      logic [2:0]  p;
      logic        cpol, cpha, wide, txo, crca, init, inv;
      logic [15:0] data;
      logic [15:0] poly;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'hA5C3, 16'h1021},
      '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h005A, 16'h0007},
      '{3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1234, 16'h1021},
      '{3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0081, 16'h0007},
      '{3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0001, 16'h1021},
      '{3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h8000, 16'h1021},
      '{3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h003C, 16'h0007},
      '{3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'hFF00, 16'h0007}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_presc = '0;
   logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_wide = 1'b0, cfg_txonly = 1'b0;
   logic [15:0] crc_poly = '0, tx_data = '0;
   logic        tx_crc_after = 1'b0, tx_crc_init = 1'b0, tx_valid = 1'b0;
   logic        inv = 1'b0;
   logic        tx_ready, rx_valid, busy, crc_err, sck, mosi, miso, cs_n;
   logic [15:0] rx_data;

   int total = 0, bad = 0;
   int cyc = 0;

   assign miso = mosi ^ inv;

   always #5 clk = !clk;
   always @(negedge clk) cyc <= cyc + 1;

   spim_crc_master u_spim_crc_master (
      .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide), .cfg_txonly(cfg_txonly),
      .crc_poly(crc_poly), .tx_crc_after(tx_crc_after), .tx_crc_init(tx_crc_init),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .crc_err(crc_err),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   // slave-side monitor: samples MOSI on the edge the mode calls for (R4)
   logic [31:0] mon_bits;
   int mon_n, lead_cnt, t_fall, t_first, t_lead2, t_last, t_rise;
   int rv_cnt;
   logic [15:0] rv_data;

   always @(negedge cs_n) begin
      mon_bits = '0; mon_n = 0; lead_cnt = 0; t_fall = cyc;
   end
   always @(posedge cs_n) t_rise = cyc;
   always @(sck) begin
      if (cs_n === 1'b0) begin
         if (sck != cfg_cpol) begin
            lead_cnt = lead_cnt + 1;
            if (lead_cnt == 1) t_first = cyc;
            if (lead_cnt == 2) t_lead2 = cyc;
         end
         if (cfg_cpha ? (sck == cfg_cpol) : (sck != cfg_cpol)) begin
            mon_bits = {mon_bits[30:0], mosi};
            mon_n = mon_n + 1;
         end
         t_last = cyc;
      end
   end
   always @(posedge clk) begin
      if (rx_valid) begin
         rv_cnt <= rv_cnt + 1;
         rv_data <= rx_data;
      end
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // CRC rule of R8
   function automatic logic [15:0] crc_run(input logic [15:0] c0, input logic [15:0] d,
                                           input logic wide, input logic [15:0] poly);
      logic [15:0] c;
      logic [15:0] m;
      logic fb;
      c = c0;
      m = wide ? 16'hFFFF : 16'h00FF;
      for (int i = (wide ? 15 : 7); i >= 0; i--) begin
         fb = (wide ? c[15] : c[7]) ^ d[i];
         c = ((c << 1) ^ (fb ? (poly & m) : 16'h0)) & m;
      end
      return c;
   endfunction

   logic [15:0] mtx = '0, mrx = '0;
   logic [31:0] exp_bits;
   int exp_n, exp_h;
   logic [15:0] exp_rx;
   logic exp_err;

   task automatic start_xfer(input vec_t v);
      logic [15:0] m;
      logic [15:0] im;
      @(negedge clk);
      cfg_presc = v.p; cfg_cpol = v.cpol; cfg_cpha = v.cpha; cfg_wide = v.wide;
      cfg_txonly = v.txo; tx_crc_after = v.crca; tx_crc_init = v.init;
      inv = v.inv; tx_data = v.data; crc_poly = v.poly;
      m = v.wide ? 16'hFFFF : 16'h00FF;
      im = v.inv ? 16'hFFFF : 16'h0;
      if (v.init) begin mtx = '0; mrx = '0; end
      mtx = crc_run(mtx, v.data & m, v.wide, v.poly);
      mrx = crc_run(mrx, (v.data ^ im) & m, v.wide, v.poly);
      exp_h = 1 << v.p;
      exp_n = (v.wide ? 16 : 8) * (v.crca ? 2 : 1);
      if (v.wide) exp_bits = v.crca ? {v.data, mtx} : {16'h0, v.data};
      else exp_bits = v.crca ? {16'h0, v.data[7:0], mtx[7:0]} : {24'h0, v.data[7:0]};
      exp_rx = (v.data ^ im) & m;
      exp_err = v.crca && !v.txo && (((mtx ^ im) & m) != mrx);
      rv_cnt = 0;
      repeat (2) @(negedge clk);
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      check(!cs_n && busy, "R1 accept lowers cs_n, raises busy", {cs_n, busy}, 2'b01);
   endtask

   task automatic finish_xfer(input vec_t v);
      do @(negedge clk); while (busy);
      @(negedge clk);
      check(mon_n == exp_n, "R5/R9 bit count", mon_n, exp_n);
      check(mon_bits == exp_bits, "R4/R9 MOSI bits, CRC frame", mon_bits, exp_bits);
      check(t_lead2 - t_first == 2 * exp_h, "R2 SCK period", t_lead2 - t_first, 2 * exp_h);
      check(t_first - t_fall == 2 * exp_h, "R3 cs_n lead", t_first - t_fall, 2 * exp_h);
      check(t_rise - t_last == 2 * exp_h, "R3 cs_n tail", t_rise - t_last, 2 * exp_h);
      check(sck == v.cpol, "R2 idle SCK level", sck, v.cpol);
      if (v.txo) begin
         check(rv_cnt == 0, "R7 no rx_valid in transmit-only", rv_cnt, 0);
         check(crc_err == 1'b0, "R7 crc_err quiet in transmit-only", crc_err, 0);
      end else begin
         check(rv_cnt == 1, "R6 one rx_valid pulse", rv_cnt, 1);
         check(rv_data == exp_rx, "R6/R5 rx_data", rv_data, exp_rx);
         check(crc_err == exp_err, "R10/R8 crc_err", crc_err, exp_err);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n && !busy && tx_ready && !rx_valid && !crc_err,
            "R1 reset state", {cs_n, busy, tx_ready, rx_valid, crc_err}, 5'b10100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         start_xfer(VECS[i]);
         finish_xfer(VECS[i]);
      end

      // directed: a frame that should flag a mismatch, then clear-on-accept
      start_xfer(VECS[2]);
      finish_xfer(VECS[2]);
      check(crc_err == 1'b1, "R10 inverted loop flags mismatch", crc_err, 1);
      check(crc_err == 1'b1, "R10 crc_err holds while idle", crc_err, 1);
      start_xfer(VECS[1]);
      check(crc_err == 1'b0, "R10 accept clears crc_err", crc_err, 0);

      // directed: a request during a transfer is ignored (R1)
      repeat (3) @(negedge clk);
      check(tx_ready == 1'b0, "R1 tx_ready low while busy", tx_ready, 0);
      tx_data = 16'hFFFF;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      finish_xfer(VECS[1]);
      repeat (4) @(negedge clk);
      check(!busy && cs_n, "R1 ignored request starts nothing", {busy, cs_n}, 2'b01);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule